// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a serial slave for a two-wire bus (SCL clock, open-drain SDA data) that gives bus access to a small bank of 16-bit registers. A master first writes a pointer byte that picks one register. Later transfers either write a 16-bit word into that register, most significant byte first, or read the word back in the same byte order. SCL and SDA are sampled by a fast system clock. The block pulls SDA low through a single output-enable. It never drives SDA high.

The register bank sits outside the block and connects through a simple port. The block presents the current pointer, reads the selected word combinationally, and issues a one-cycle write strobe with a full word. The block also answers the bus-wide general-call address. It acts on two command bytes sent there: one re-samples the address-select pins, and one returns the pointer and the external bank to their power-up state. It recognises the high-speed master code, leaves it unacknowledged, and reports high-speed operation on a flag until the next stop.

Top module: `regptr_i2c_slave`

## Requirements
- R1: The 7-bit slave address is `{ADDR_BASE[6:ADDR_PIN_W], pins}`. An address byte whose upper seven bits match it is acknowledged. A non-matching, non-special address leaves SDA released in the ninth clock.
- R2: In a write (address bit 0 = 0), the byte after the address is acknowledged and its low `PTR_W` bits become `rfPtr`.
- R3: The first data byte after the pointer is the high byte and the second is the low byte. Both are acknowledged. Exactly one `rfWrEn` pulse, carrying the word, follows the second byte.
- R4: Data bytes after the second in one write are acknowledged, but they produce no further `rfWrEn` pulse and leave the register unchanged.
- R5: In a read (address bit 0 = 1), the block returns bits 15:8 and then bits 7:0 of the selected register. If the master acknowledges the low byte, the register is captured again and the high byte follows, then the low byte.
- R6: A master NACK ends a read, and SDA stays released until the next start. A start condition (SDA falling while SCL is high) restarts address reception at any point. A stop condition (SDA rising while SCL is high) ends any transfer.
- R7: The general-call byte 0x00 is acknowledged. The byte 0x01 is not acknowledged.
- R8: The address-select pins are sampled at reset and on the general-call command 0x04 only. Pin changes between these events do not change the address.
- R9: The general-call command 0x06 clears the pointer to 0 and gives one `gcResetPulse` cycle.
- R10: A first byte after a start matching `00001xxx` is not acknowledged and sets `hsMode`. A repeated start leaves `hsMode` set, and a stop clears it.
- R11: SDA output changes happen only while SCL is low. An acknowledge is held low for the whole ninth SCL high phase.
- R12: During reset, `sdaOe`, `hsMode`, `rfWrEn` and `gcResetPulse` are 0 and `rfPtr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | 1 pulls SDA low |
| addrPins | input | ADDR_PIN_W | Address-select pins |
| rfPtr | output | PTR_W | Register index held by the pointer |
| rfRdData | input | 16 | Word read from the selected register |
| rfWrEn | output | 1 | One-cycle write strobe |
| rfWrData | output | 16 | Word to write |
| gcResetPulse | output | 1 | One-cycle request to restore bank power-up values |
| hsMode | output | 1 | High-speed master code seen since the last stop |

## Verification
The hardest situation to reach is the read continuation and read termination path. Here the block must hand SDA back to the master in the ninth clock, sample the master's acknowledge, and then either capture the register again and drive a new high byte, or stay silent. The bench gets there by reading four bytes with every byte acknowledged, and separately by NACKing the low byte and then clocking a further byte that must read back as all ones. It also sets the pointer and reads in one transfer through a repeated start. High-speed mode is reached by sending the master code, then a repeated start, then a stop, with `hsMode` checked after each step.

// File: rtl/regptr_i2c_pkg.sv
package regptr_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_GCCMD,
    ST_TX
  } busState_t;

  typedef struct packed {
    logic shiftIn;     // shift sampled SDA into the receive register
    logic ptrLoad;     // receive byte becomes the pointer
    logic stageLoad;   // receive byte becomes the staged high byte
    logic wordWrite;   // issue the register write strobe
    logic latchPins;   // resample address-select pins
    logic gcReset;     // general-call reset command
    logic txLoadMsb;   // capture register word, drive bit 15
    logic txLoadLsb;   // load held low byte, drive bit 7
    logic txShift;     // advance to next transmit bit
    logic ackDrive;    // pull SDA low for acknowledge
    logic sdaRelease;  // stop pulling SDA
    logic hsSet;       // high-speed code seen
    logic hsClear;     // stop condition clears high-speed flag
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      logic sclQ, sdaQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sclChain, sdaChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclChain[SYNC_STAGES-1];
      assign sdaS = sdaChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2c_ptr_ctrl.sv
module i2c_ptr_ctrl
  import regptr_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic [6:0] myAddr,
  output ctlStrobe_t strb
);

  localparam logic [3:0] BIT_DECIDE = 4'd8;
  localparam logic [3:0] BIT_ACKEND = 4'd9;
  localparam logic [7:0] GC_ADDR    = 8'h00;
  localparam logic [7:0] GC_LATCH   = 8'h04;
  localparam logic [7:0] GC_RESET   = 8'h06;
  localparam logic [4:0] HS_PREFIX  = 5'b00001;

  busState_t  state, nextState, nextDec;
  logic [3:0] bitCnt;
  logic [1:0] wrIdx;
  logic       txLsb;
  logic       masterNack;
  logic       active;

  assign active = (state != ST_IDLE) && !startDet && !stopDet;

  always_comb begin
    strb    = '0;
    nextDec = nextState;
    if (startDet || stopDet) strb.sdaRelease = 1'b1;
    if (stopDet)             strb.hsClear    = 1'b1;
    if (active && sclRise && bitCnt < BIT_DECIDE) strb.shiftIn = 1'b1;
    if (active && sclFall) begin
      if (bitCnt == BIT_DECIDE) begin
        unique case (state)
          ST_ADDR: begin
            if (rxByte[7:1] == myAddr) begin
              strb.ackDrive = 1'b1;
              nextDec = rxByte[0] ? ST_TX : ST_PTR;
            end else if (rxByte == GC_ADDR) begin
              strb.ackDrive = 1'b1;
              nextDec = ST_GCCMD;
            end else if (rxByte[7:3] == HS_PREFIX) begin
              strb.hsSet = 1'b1;
              strb.sdaRelease = 1'b1;
              nextDec = ST_IDLE;
            end else begin
              strb.sdaRelease = 1'b1;
              nextDec = ST_IDLE;
            end
          end
          ST_PTR: begin
            strb.ackDrive = 1'b1;
            strb.ptrLoad  = 1'b1;
            nextDec = ST_WDATA;
          end
          ST_WDATA: begin
            strb.ackDrive  = 1'b1;
            strb.stageLoad = (wrIdx == 2'd0);
            strb.wordWrite = (wrIdx == 2'd1);
            nextDec = ST_WDATA;
          end
          ST_GCCMD: begin
            strb.ackDrive  = 1'b1;
            strb.latchPins = (rxByte == GC_LATCH);
            strb.gcReset   = (rxByte == GC_RESET);
            nextDec = ST_IDLE;
          end
          ST_TX: begin
            strb.sdaRelease = 1'b1;
            nextDec = ST_TX;
          end
          default: nextDec = ST_IDLE;
        endcase
      end else if (bitCnt == BIT_ACKEND) begin
        if (state == ST_TX && masterNack) strb.sdaRelease = 1'b1;
        else if (nextState == ST_TX) begin
          if (txLsb) strb.txLoadLsb = 1'b1;
          else       strb.txLoadMsb = 1'b1;
        end else strb.sdaRelease = 1'b1;
      end else if (state == ST_TX && bitCnt != 4'd0) begin
        strb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      nextState  <= ST_IDLE;
      bitCnt     <= '0;
      wrIdx      <= '0;
      txLsb      <= 1'b0;
      masterNack <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (state != ST_IDLE) begin
      if (sclRise && bitCnt < BIT_ACKEND) begin
        bitCnt <= bitCnt + 4'd1;
        if (bitCnt == BIT_DECIDE) masterNack <= sdaS;
      end
      if (sclFall) begin
        if (bitCnt == BIT_DECIDE) begin
          nextState <= nextDec;
          if (state == ST_PTR) wrIdx <= 2'd0;
          if (state == ST_WDATA && wrIdx != 2'd2) wrIdx <= wrIdx + 2'd1;
          if (state == ST_ADDR) txLsb <= 1'b0;
          if (state == ST_TX)   txLsb <= ~txLsb;
        end else if (bitCnt == BIT_ACKEND) begin
          bitCnt <= '0;
          state  <= (state == ST_TX && masterNack) ? ST_IDLE : nextState;
        end
      end
    end
  end

  // R6: a start always realigns the byte framing to a fresh address byte
  p_start_realign_r6: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == 4'd0));

  // R4: the write index saturates, so extra bytes cannot reach the write strobe
  p_extra_bytes_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrIdx == 2'd2) |-> !strb.wordWrite);

endmodule

// File: rtl/i2c_ptr_dpath.sv
module i2c_ptr_dpath
  import regptr_i2c_pkg::*;
#(
  parameter int         ADDR_PIN_W = 2,
  parameter logic [6:0] ADDR_BASE  = 7'h48,
  parameter int         PTR_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaS,
  input  logic                  sclS,
  input  ctlStrobe_t            strb,
  input  logic [ADDR_PIN_W-1:0] addrPins,
  input  logic [15:0]           rfRdData,
  output logic [7:0]            rxByte,
  output logic [6:0]            myAddr,
  output logic [PTR_W-1:0]      rfPtr,
  output logic                  rfWrEn,
  output logic [15:0]           rfWrData,
  output logic                  gcResetPulse,
  output logic                  sdaOe,
  output logic                  hsMode
);

  localparam int FIXED_W = 7 - ADDR_PIN_W;

  logic [7:0]            rxShift;
  logic [ADDR_PIN_W-1:0] pinLatch;
  logic [PTR_W-1:0]      ptrReg;
  logic [7:0]            stageMsb;
  logic [7:0]            lsbHold;
  logic [7:0]            txReg;
  logic                  sdaOeR;
  logic                  hsR;
  logic                  wrEnR;
  logic [15:0]           wrDataR;
  logic                  gcR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      pinLatch <= addrPins;
      ptrReg   <= '0;
      stageMsb <= '0;
      lsbHold  <= '0;
      txReg    <= '0;
      sdaOeR   <= 1'b0;
      hsR      <= 1'b0;
      wrEnR    <= 1'b0;
      wrDataR  <= '0;
      gcR      <= 1'b0;
    end else begin
      wrEnR <= 1'b0;
      gcR   <= 1'b0;
      if (strb.shiftIn)   rxShift  <= {rxShift[6:0], sdaS};
      if (strb.ptrLoad)   ptrReg   <= rxShift[PTR_W-1:0];
      if (strb.stageLoad) stageMsb <= rxShift;
      if (strb.wordWrite) begin
        wrEnR   <= 1'b1;
        wrDataR <= {stageMsb, rxShift};
      end
      if (strb.latchPins) pinLatch <= addrPins;
      if (strb.gcReset) begin
        gcR    <= 1'b1;
        ptrReg <= '0;
      end
      if (strb.hsSet)   hsR <= 1'b1;
      if (strb.hsClear) hsR <= 1'b0;
      if (strb.txLoadMsb) begin
        txReg   <= rfRdData[15:8];
        lsbHold <= rfRdData[7:0];
        sdaOeR  <= ~rfRdData[15];
      end else if (strb.txLoadLsb) begin
        txReg  <= lsbHold;
        sdaOeR <= ~lsbHold[7];
      end else if (strb.txShift) begin
        txReg  <= {txReg[6:0], 1'b0};
        sdaOeR <= ~txReg[6];
      end else if (strb.ackDrive) begin
        sdaOeR <= 1'b1;
      end else if (strb.sdaRelease) begin
        sdaOeR <= 1'b0;
      end
    end
  end

  assign rxByte       = rxShift;
  assign myAddr       = {ADDR_BASE[6:7-FIXED_W], pinLatch};
  assign rfPtr        = ptrReg;
  assign rfWrEn       = wrEnR;
  assign rfWrData     = wrDataR;
  assign gcResetPulse = gcR;
  assign sdaOe        = sdaOeR;
  assign hsMode       = hsR;

  // R11: the output enable only moves after SCL has been seen low
  p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclS));

  // R3: each word write is a single-cycle strobe
  p_one_write_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> !rfWrEn);

  // R9: a general-call reset leaves the pointer at zero
  p_gc_clears_ptr_r9: assert property (@(posedge clk) disable iff (!rstN)
    gcResetPulse |-> (rfPtr == '0));

  // R10: the high-speed code is never acknowledged
  p_hs_not_acked_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> !sdaOe);

endmodule

// File: rtl/regptr_i2c_slave.sv
module regptr_i2c_slave
  import regptr_i2c_pkg::*;
#(
  parameter int         ADDR_PIN_W  = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h48,
  parameter int         PTR_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [ADDR_PIN_W-1:0] addrPins,
  output logic [PTR_W-1:0]      rfPtr,
  input  logic [15:0]           rfRdData,
  output logic                  rfWrEn,
  output logic [15:0]           rfWrData,
  output logic                  gcResetPulse,
  output logic                  hsMode
);

  logic       sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic [6:0] myAddr;
  ctlStrobe_t strb;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_ptr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS),
    .rxByte(rxByte), .myAddr(myAddr), .strb(strb)
  );

  i2c_ptr_dpath #(
    .ADDR_PIN_W(ADDR_PIN_W), .ADDR_BASE(ADDR_BASE), .PTR_W(PTR_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclS(sclS), .strb(strb),
    .addrPins(addrPins), .rfRdData(rfRdData), .rxByte(rxByte),
    .myAddr(myAddr), .rfPtr(rfPtr), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .gcResetPulse(gcResetPulse), .sdaOe(sdaOe), .hsMode(hsMode)
  );

endmodule

// File: tb/test_regptr_i2c_slave.sv
module test_regptr_i2c_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int PTR_W      = 2;
  localparam int NREG       = 1 << PTR_W;
  localparam int WDOG       = 150000;
  localparam logic [23:0] VEC [4] = '{24'h00_BEEF, 24'h03_1234, 24'h01_8001, 24'h06_7F00};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] addrPins = 2'b00;
  logic sdaOe, rfWrEn, gcResetPulse, hsMode, sdaLine;
  logic [PTR_W-1:0] rfPtr;
  logic [15:0] rfRdData, rfWrData;
  logic [15:0] bank [NREG];
  int checks = 0, failures = 0, wrPulses = 0, gcPulses = 0, oeViol = 0;
  bit done = 0;
  logic oePrev = 1'b0, sclPrevB = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine  = sdaDrv & ~sdaOe;
  assign rfRdData = bank[rfPtr];

  regptr_i2c_slave i_regptr_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrPins(addrPins), .rfPtr(rfPtr), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrData(rfWrData), .gcResetPulse(gcResetPulse), .hsMode(hsMode)
  );

  function automatic logic [15:0] rstVal(int k);
    return 16'h0A00 + 16'(k * 17);
  endfunction

  always @(posedge clk) begin
    if (!rstN || gcResetPulse) begin
      for (int k = 0; k < NREG; k++) bank[k] <= rstVal(k);
    end else if (rfWrEn) bank[rfPtr] <= rfWrData;
    if (rfWrEn) wrPulses++;
    if (gcResetPulse) gcPulses++;
  end

  // R11 port monitor: enable must not move while the bench holds SCL high
  always @(negedge clk) begin
    if (rstN && sclDrv && sclPrevB && sdaOe != oePrev) oeViol++;
    oePrev   <= sdaOe;
    sclPrevB <= sclDrv;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitQ(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ(2);
    sdaDrv = 1'b0; waitQ(2);
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ(2);
    sdaDrv = 1'b1; waitQ(2);
  endtask

  // returns 2'b00 when the slave held an acknowledge for the whole high phase
  task automatic sendByte(input logic [7:0] b, output logic [1:0] ackS);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ(2);
      sclDrv = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    ackS[1] = sdaLine;
    repeat (Q - 1) @(negedge clk);
    ackS[0] = sdaLine;
    @(negedge clk);
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; waitQ();
      sclDrv = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      sclDrv = 1'b0; waitQ();
    end
    sdaDrv = mAck ? 1'b0 : 1'b1; waitQ();
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  task automatic wrTxn(input logic [6:0] a, input logic [7:0] p, input logic [15:0] w,
                       input int extra, output bit allAck);
    logic [1:0] ak;
    allAck = 1;
    i2cStart();
    sendByte({a, 1'b0}, ak); if (ak != 2'b00) allAck = 0;
    sendByte(p, ak);         if (ak != 2'b00) allAck = 0;
    sendByte(w[15:8], ak);   if (ak != 2'b00) allAck = 0;
    sendByte(w[7:0], ak);    if (ak != 2'b00) allAck = 0;
    for (int e = 0; e < extra; e++) begin
      sendByte(8'hE0 + 8'(e), ak); if (ak != 2'b00) allAck = 0;
    end
    i2cStop();
  endtask

  task automatic rdTxn(input logic [6:0] a, input int n, output logic [31:0] d, output bit aAck);
    logic [1:0] ak;
    logic [7:0] b;
    d = '0;
    i2cStart();
    sendByte({a, 1'b1}, ak);
    aAck = (ak == 2'b00);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      d = {d[23:0], b};
    end
    i2cStop();
  endtask

  task automatic addrProbe(input logic [7:0] b, output logic [1:0] ak);
    i2cStart();
    sendByte(b, ak);
    i2cStop();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [1:0] ak;
    logic [31:0] d;
    logic [6:0] devAddr;
    int w0;
    devAddr = 7'h48;

    repeat (5) @(negedge clk);
    // R12: reset state
    chk(!sdaOe && !hsMode && !rfWrEn && !gcResetPulse, "R12", "reset outputs",
        {28'd0, sdaOe, hsMode, rfWrEn, gcResetPulse}, 32'd0);
    chk(rfPtr == '0, "R12", "reset pointer", 32'(rfPtr), 32'd0);
    rstN = 1'b1;
    waitQ(2);

    // table walk: write a word via a pointer, read it back (R1 R2 R3 R5)
    for (int v = 0; v < 4; v++) begin
      wrTxn(devAddr, VEC[v][23:16], VEC[v][15:0], 0, ok);
      chk(ok, "R1", "write transfer acks", 32'(ok), 32'd1);
      chk(rfPtr == VEC[v][16 +: PTR_W], "R2", "pointer low bits", 32'(rfPtr), 32'(VEC[v][16 +: PTR_W]));
      chk(bank[VEC[v][16 +: PTR_W]] == VEC[v][15:0], "R3", "word written",
          32'(bank[VEC[v][16 +: PTR_W]]), 32'(VEC[v][15:0]));
      rdTxn(devAddr, 2, d, ok);
      chk(ok && d[15:0] == VEC[v][15:0], "R5", "read high then low",
          d, {16'd0, VEC[v][15:0]});
    end

    // R1: a different address is left unacknowledged
    addrProbe({7'h4C, 1'b0}, ak);
    chk(ak == 2'b11, "R1", "foreign address nack", 32'(ak), 32'h3);

    // R4: extra bytes acked, one write only
    w0 = wrPulses;
    wrTxn(devAddr, 8'h02, 16'hC0DE, 2, ok);
    chk(ok, "R4", "extra bytes acked", 32'(ok), 32'd1);
    chk(wrPulses - w0 == 1, "R4", "single write pulse", 32'(wrPulses - w0), 32'd1);
    chk(bank[2] == 16'hC0DE, "R4", "register keeps first word", 32'(bank[2]), 32'hC0DE);

    // R5: acknowledged low byte continues with a fresh high byte
    rdTxn(devAddr, 4, d, ok);
    chk(d == 32'hC0DEC0DE, "R5", "four byte read", d, 32'hC0DEC0DE);

    // R6: NACK ends read, SDA stays released
    i2cStart();
    sendByte({devAddr, 1'b1}, ak);
    recvByte(1'b1, d[15:8]);
    recvByte(1'b0, d[7:0]);
    recvByte(1'b0, d[23:16]);
    i2cStop();
    chk(d[23:16] == 8'hFF, "R6", "released after nack", 32'(d[23:16]), 32'hFF);

    // R6: pointer set then repeated start into a read
    i2cStart();
    sendByte({devAddr, 1'b0}, ak);
    sendByte(8'h01, ak);
    i2cStart();
    sendByte({devAddr, 1'b1}, ak);
    recvByte(1'b1, d[15:8]);
    recvByte(1'b0, d[7:0]);
    i2cStop();
    chk(d[15:0] == 16'h8001, "R6", "repeated start read", 32'(d[15:0]), 32'h8001);

    // R7: general call acknowledged only with bit 0 low
    addrProbe(8'h00, ak);
    chk(ak == 2'b00, "R7", "general call ack", 32'(ak), 32'h0);
    addrProbe(8'h01, ak);
    chk(ak == 2'b11, "R7", "general call read nack", 32'(ak), 32'h3);

    // R8: pin change has no effect until latch command
    addrPins = 2'b01;
    waitQ();
    addrProbe({7'h49, 1'b0}, ak);
    chk(ak == 2'b11, "R8", "new address before latch", 32'(ak), 32'h3);
    addrProbe({7'h48, 1'b0}, ak);
    chk(ak == 2'b00, "R8", "old address before latch", 32'(ak), 32'h0);
    i2cStart();
    sendByte(8'h00, ak);
    sendByte(8'h04, ak);
    i2cStop();
    chk(ak == 2'b00, "R8", "latch command ack", 32'(ak), 32'h0);
    devAddr = 7'h49;
    addrProbe({7'h49, 1'b0}, ak);
    chk(ak == 2'b00, "R8", "new address after latch", 32'(ak), 32'h0);
    addrProbe({7'h48, 1'b0}, ak);
    chk(ak == 2'b11, "R8", "old address after latch", 32'(ak), 32'h3);

    // R9: general-call reset
    w0 = gcPulses;
    i2cStart();
    sendByte(8'h00, ak);
    sendByte(8'h06, ak);
    i2cStop();
    chk(gcPulses - w0 == 1, "R9", "reset pulse count", 32'(gcPulses - w0), 32'd1);
    chk(rfPtr == '0, "R9", "pointer cleared", 32'(rfPtr), 32'd0);
    rdTxn(devAddr, 2, d, ok);
    chk(d[15:0] == rstVal(0), "R9", "register 0 restored", 32'(d[15:0]), 32'(rstVal(0)));

    // R10: high-speed code
    i2cStart();
    sendByte(8'h0B, ak);
    chk(ak == 2'b11, "R10", "hs code nack", 32'(ak), 32'h3);
    chk(hsMode, "R10", "hs flag set", 32'(hsMode), 32'd1);
    i2cStart();
    sendByte({devAddr, 1'b0}, ak);
    chk(ak == 2'b00 && hsMode, "R10", "hs kept over repeated start",
        {30'd0, ak}, 32'd0);
    i2cStop();
    waitQ();
    chk(!hsMode, "R10", "hs cleared by stop", 32'(hsMode), 32'd0);

    // R11: enable never moved while SCL high (ack hold checked in sendByte samples)
    chk(oeViol == 0, "R11", "sda moved with scl high", 32'(oeViol), 32'd0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule